// File: doc/BRIEF.md
# Two-Bit Correcting Decoder for a Weighted Zero-Sum Code

This block takes one received 10-bit codeword of a weighted, systematic, delay-insensitive code and returns a corrected word with a status flag. The code has four data bits, a five-bit check field and one even-parity bit. The check field holds the binary sum of the weights of every data bit that is zero. The syndrome is the absolute difference between the check field recomputed from the received data and the check field that was received.

A word is classified in one cycle by its parity and its syndrome. A clean word passes through unchanged. A single error is repaired directly. An even-parity word with a nonzero syndrome starts a search. The search tests one candidate per clock: the received word with one pair of bits inverted, for each of the 45 bit pairs in a fixed order. It keeps the number of candidates whose syndrome is zero, saturated at two, together with the first such candidate. The outcome is reported with a single-cycle `done` pulse.

Top module: `zsx_corrector`

## Requirements
- R1: Bit positions of the word are data bits at 9..6 with weights 3, 7, 11, 5, check bits at 5..1 with weights 16, 8, 4, 2, 1 (bit 1 weighs 1), and the parity bit at 0 with weight 0. A valid word has an even number of ones, and its check field equals the sum of the weights of its zero data bits.
- R2: A word with even parity and zero syndrome is returned unchanged with `no_error`, and `done` rises one cycle after the edge that accepts `start`.
- R3: A word with odd parity and a nonzero syndrome equal to the weight of some bit position is returned with that bit inverted and with `corrected1`.
- R4: A word with odd parity and zero syndrome is returned with bit 0 inverted and with `corrected1`.
- R5: A word with odd parity and a nonzero syndrome that equals no position weight is returned unchanged with `uncorrectable`.
- R6: A word with even parity and a nonzero syndrome is searched over all 45 pairs (i<j) in lexicographic order, one pair per cycle. `busy` stays high during the search, and `done` rises 47 cycles after the accepting edge.
- R7: If exactly one pair candidate has zero syndrome, that candidate is returned with `corrected2`. It differs from the received word in exactly two bits.
- R8: If two or more pair candidates have zero syndrome, the received word is returned unchanged with `ambiguous`.
- R9: If no pair candidate has zero syndrome, the received word is returned unchanged with `uncorrectable`.
- R10: `start` is ignored while `busy` is high. The result of the word in progress is not altered.
- R11: Exactly one of the five status flags is high whenever `done` is high, and `done` lasts one cycle.
- R12: After reset, `busy`, `done` and all status flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accept `rx_word` when idle |
| rx_word | input | 10 | Received codeword |
| busy | output | 1 | A word is being processed |
| done | output | 1 | One-cycle result strobe |
| word_out | output | 10 | Corrected (or unchanged) word |
| no_error | output | 1 | Word was clean |
| corrected1 | output | 1 | One bit was repaired |
| corrected2 | output | 1 | Two bits were repaired |
| ambiguous | output | 1 | Several double-error explanations exist |
| uncorrectable | output | 1 | No repair was possible |

## Verification
All 16 clean codewords are applied to separate the no-action path from every repair path. Every single-bit corruption of every codeword is applied; this separates data and check repairs (R3) from the parity toggle (R4). Every double corruption of every codeword is applied and compared with an independent brute-force model. These inputs split into unique repairs and ambiguous outcomes and also confirm the scan latency. Exhaustive triple and quadruple corruptions of chosen codewords reach the unnamed-syndrome and zero-survivor outcomes. A start pulse injected in mid-search shows that a busy block ignores it.

// File: rtl/zsx_pkg.sv
package zsx_pkg;
  localparam int DATA_W = 4;
  localparam int CHK_W  = 5;
  localparam int WORD_W = DATA_W + CHK_W + 1;
  localparam int SYN_W  = CHK_W;
  localparam int POS_W  = $clog2(WORD_W);
  localparam int FLAG_W = 5;

  // weight of data bit k, data bit k sits at word position CHK_W+1+k
  localparam int DATA_WT [DATA_W] = '{5, 11, 7, 3};

  // status flag one-hot codes
  localparam logic [FLAG_W-1:0] F_NOERR = 5'b00001;
  localparam logic [FLAG_W-1:0] F_COR1  = 5'b00010;
  localparam logic [FLAG_W-1:0] F_COR2  = 5'b00100;
  localparam logic [FLAG_W-1:0] F_AMB   = 5'b01000;
  localparam logic [FLAG_W-1:0] F_UNC   = 5'b10000;

  function automatic logic [SYN_W-1:0] weight_of(input int pos);
    if (pos >= 1 && pos <= CHK_W) return SYN_W'(1 << (pos - 1));
    if (pos > CHK_W && pos < WORD_W) return SYN_W'(DATA_WT[pos - CHK_W - 1]);
    return '0;
  endfunction

  function automatic logic [SYN_W-1:0] check_of(input logic [DATA_W-1:0] d);
    int acc;
    acc = 0;
    for (int k = 0; k < DATA_W; k++)
      if (!d[k]) acc += DATA_WT[k];
    return SYN_W'(acc);
  endfunction

  function automatic logic [SYN_W-1:0] syndrome_of(input logic [WORD_W-1:0] w);
    logic [SYN_W-1:0] regen;
    logic [SYN_W-1:0] recv;
    regen = check_of(w[WORD_W-1 -: DATA_W]);
    recv  = w[CHK_W:1];
    return (regen > recv) ? regen - recv : recv - regen;
  endfunction

  function automatic logic [WORD_W-1:0] single_mask(input logic [SYN_W-1:0] syn);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int p = 1; p < WORD_W; p++)
      if (weight_of(p) == syn) m[p] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/zsx_syndrome.sv
module zsx_syndrome
  import zsx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic [W-1:0]     word,
  output logic [SYN_W-1:0] syn,
  output logic             odd,
  output logic             zero
);
  always_comb begin
    syn  = syndrome_of(word);
    odd  = ^word;
    zero = (syn == '0);
  end
endmodule

// File: rtl/zsx_pair_walker.sv
module zsx_pair_walker
  import zsx_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int PW = POS_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  output logic [W-1:0] flip,
  output logic         last
);
  localparam logic [PW-1:0] TOP_POS = PW'(W - 1);
  localparam logic [PW-1:0] LO_END  = PW'(W - 2);

  logic [PW-1:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      lo_q <= '0;
      hi_q <= PW'(1);
    end else if (step) begin
      if (hi_q == TOP_POS) begin
        lo_q <= lo_q + PW'(1);
        hi_q <= lo_q + PW'(2);
      end else begin
        hi_q <= hi_q + PW'(1);
      end
    end
  end

  always_comb begin
    flip = (W'(1) << lo_q) | (W'(1) << hi_q);
    last = (lo_q == LO_END) && (hi_q == TOP_POS);
  end

  // R6
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (lo_q < hi_q) && (hi_q <= TOP_POS));
endmodule

// File: rtl/zsx_survivor_tally.sv
module zsx_survivor_tally
  import zsx_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic         hit,
  input  logic [W-1:0] cand,
  output logic [1:0]   count,
  output logic [W-1:0] first
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= 2'd0;
      first <= '0;
    end else if (step && hit) begin
      if (count == 2'd0) first <= cand;
      if (count != 2'd2) count <= count + 2'd1;
    end
  end

  // R7
  tally_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear) |=> (count >= $past(count)) && (count <= 2'd2));
endmodule

// File: rtl/zsx_corrector.sv
module zsx_corrector
  import zsx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] rx_word,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] word_out,
  output logic              no_error,
  output logic              corrected1,
  output logic              corrected2,
  output logic              ambiguous,
  output logic              uncorrectable
);
  typedef enum logic [1:0] {ST_IDLE, ST_CLASS, ST_SCAN, ST_FIN} state_t;

  state_t             state_q;
  logic [WORD_W-1:0]  rx_q, word_q;
  logic [FLAG_W-1:0]  flags_q;
  logic               done_q;

  // named internal events
  logic [SYN_W-1:0]   rx_syn, cand_syn;
  logic               rx_odd, rx_zero, cand_odd, cand_zero;
  logic [WORD_W-1:0]  flip, cand, first;
  logic               last_pair, need_scan, in_class, in_scan;
  logic [1:0]         surv_cnt;
  logic [WORD_W-1:0]  cls_word, fin_word, one_mask;
  logic [FLAG_W-1:0]  cls_flags, fin_flags;

  assign in_class = (state_q == ST_CLASS);
  assign in_scan  = (state_q == ST_SCAN);
  assign cand     = rx_q ^ flip;

  zsx_syndrome #(.W(WORD_W)) u_rx_syn (
    .word(rx_q), .syn(rx_syn), .odd(rx_odd), .zero(rx_zero));

  zsx_syndrome #(.W(WORD_W)) u_cand_syn (
    .word(cand), .syn(cand_syn), .odd(cand_odd), .zero(cand_zero));

  zsx_pair_walker #(.W(WORD_W), .PW(POS_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .clear(in_class), .step(in_scan),
    .flip(flip), .last(last_pair));

  zsx_survivor_tally #(.W(WORD_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clear(in_class), .step(in_scan),
    .hit(cand_zero), .cand(cand), .count(surv_cnt), .first(first));

  // classification of the received word
  always_comb begin
    cls_word  = rx_q;
    cls_flags = F_UNC;
    need_scan = 1'b0;
    one_mask  = single_mask(rx_syn);
    if (!rx_odd) begin
      if (rx_zero) cls_flags = F_NOERR;
      else         need_scan = 1'b1;
    end else if (rx_zero) begin
      cls_word  = rx_q ^ WORD_W'(1);
      cls_flags = F_COR1;
    end else if (one_mask != '0) begin
      cls_word  = rx_q ^ one_mask;
      cls_flags = F_COR1;
    end
  end

  // verdict after the pair search
  always_comb begin
    fin_word  = rx_q;
    fin_flags = F_UNC;
    case (surv_cnt)
      2'd1: begin fin_word = first; fin_flags = F_COR2; end
      2'd2: fin_flags = F_AMB;
      default: fin_flags = F_UNC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rx_q    <= '0;
      word_q  <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start) begin
          rx_q    <= rx_word;
          state_q <= ST_CLASS;
        end
        ST_CLASS: if (need_scan) begin
          state_q <= ST_SCAN;
        end else begin
          word_q  <= cls_word;
          flags_q <= cls_flags;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        ST_SCAN: if (last_pair) state_q <= ST_FIN;
        default: begin
          word_q  <= fin_word;
          flags_q <= fin_flags;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy          = (state_q != ST_IDLE);
  assign done          = done_q;
  assign word_out      = word_q;
  assign no_error      = flags_q[0];
  assign corrected1    = flags_q[1];
  assign corrected2    = flags_q[2];
  assign ambiguous     = flags_q[3];
  assign uncorrectable = flags_q[4];

  // R11
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $countones(flags_q) == 1);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  start_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(rx_q));

  // R3
  single_fix_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && corrected1) |-> $countones(word_out ^ rx_q) == 1);

  // R7
  double_fix_dist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && corrected2) |-> $countones(word_out ^ rx_q) == 2);

  // R7
  cand_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_scan |-> !cand_odd);

  // R8
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (ambiguous || uncorrectable || no_error)) |-> word_out == rx_q);
endmodule

// File: tb/zsx_corrector_test.sv
module zsx_corrector_test;
  localparam time TCK = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [9:0] rx_word = '0;
  logic       busy, done, no_error, corrected1, corrected2, ambiguous, uncorrectable;
  logic [9:0] word_out;

  int checks = 0;
  int errors = 0;
  int seen_c2 = 0;
  int seen_amb = 0;

  always #(TCK/2) clk = ~clk;

  zsx_corrector uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_word(rx_word),
    .busy(busy), .done(done), .word_out(word_out),
    .no_error(no_error), .corrected1(corrected1), .corrected2(corrected2),
    .ambiguous(ambiguous), .uncorrectable(uncorrectable));

  function automatic int b_wt(input int pos);
    int t[10] = '{0, 1, 2, 4, 8, 16, 5, 11, 7, 3};
    return t[pos];
  endfunction

  function automatic int b_syn(input logic [9:0] w);
    int s = 0;
    for (int p = 6; p < 10; p++) if (w[p] == 1'b0) s += b_wt(p);
    s -= int'(w[5:1]);
    return (s < 0) ? -s : s;
  endfunction

  function automatic logic [9:0] b_enc(input logic [3:0] d);
    logic [9:0] w;
    w = {d, 6'b0};
    w[5:1] = 5'(b_syn(w));
    w[0] = ^w[9:1];
    return w;
  endfunction

  // classes: 0 clean, 1 one fix, 2 two fix, 3 ambiguous, 4 uncorrectable
  task automatic b_model(input logic [9:0] r, output logic [9:0] w, output int cls);
    int s, n;
    logic [9:0] c, firstc;
    s = b_syn(r); w = r; cls = 4; n = 0; firstc = r;
    if (!(^r)) begin
      if (s == 0) cls = 0;
      else begin
        for (int i = 0; i < 10; i++)
          for (int j = i + 1; j < 10; j++) begin
            c = r ^ (10'd1 << i) ^ (10'd1 << j);
            if (b_syn(c) == 0) begin n++; if (n == 1) firstc = c; end
          end
        if (n == 1) begin w = firstc; cls = 2; end
        else if (n > 1) cls = 3;
      end
    end else if (s == 0) begin
      w = r ^ 10'd1; cls = 1;
    end else begin
      for (int p = 1; p < 10; p++)
        if (b_wt(p) == s) begin w = r ^ (10'd1 << p); cls = 1; end
    end
  endtask

  function automatic string tag_of(input int cls, input logic [9:0] r);
    case (cls)
      0: return "R2";
      1: return (b_syn(r) == 0) ? "R4" : "R3";
      2: return "R7";
      3: return "R8";
      default: return (^r) ? "R5" : "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive a word; optionally inject a second start in mid-run
  task automatic run_word(input logic [9:0] r, input bit inject, input logic [9:0] other,
                          output int lat);
    @(negedge clk); rx_word = r; start = 1'b1;
    @(negedge clk); start = 1'b0;
    lat = 0;
    while (lat < 200) begin
      @(posedge clk); @(negedge clk); lat++;
      if (inject && lat == 5) begin rx_word = other; start = 1'b1; end
      if (inject && lat == 6) start = 1'b0;
      if (done) break;
    end
  endtask

  task automatic check_word(input logic [9:0] r);
    logic [9:0] ew;
    int cls, lat, explat;
    string tg;
    b_model(r, ew, cls);
    tg = tag_of(cls, r);
    explat = (!(^r) && b_syn(r) != 0) ? 47 : 1;
    run_word(r, 1'b0, '0, lat);
    chk(lat == explat, (explat == 47) ? "R6" : "R2", lat, explat);
    chk(word_out == ew && {uncorrectable, ambiguous, corrected2, corrected1, no_error} == 5'(1 << cls),
        tg, {uncorrectable, ambiguous, corrected2, corrected1, no_error, word_out},
        {5'(1 << cls), ew});
    if (cls == 2) seen_c2++;
    if (cls == 3) seen_amb++;
  endtask

  task automatic t_reset;
    chk(!busy && !done && !no_error && !corrected1 && !corrected2 && !ambiguous && !uncorrectable,
        "R12", {busy, done, no_error, corrected1, corrected2, ambiguous, uncorrectable}, 0);
  endtask

  task automatic t_literal;
    // R1: data 0000 -> check 26, parity 1; data 1111 -> check 0, parity 0
    chk(b_enc(4'b0000) == 10'b0000_11010_1, "R1", b_enc(4'b0000), 10'b0000110101);
    check_word(10'b0000_11010_1);
    chk(no_error, "R1", no_error, 1);
    check_word(10'b1111_00000_0);
    chk(no_error, "R1", no_error, 1);
  endtask

  task automatic t_clean;
    for (int d = 0; d < 16; d++) check_word(b_enc(4'(d)));
  endtask

  task automatic t_single;
    for (int d = 0; d < 16; d++)
      for (int p = 0; p < 10; p++) check_word(b_enc(4'(d)) ^ (10'd1 << p));
  endtask

  task automatic t_double;
    logic [9:0] r;
    int lat;
    r = b_enc(4'd6) ^ 10'b0000000110;
    @(negedge clk); rx_word = r; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy && !done, "R6", {busy, done}, 2'b10);
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    for (int d = 0; d < 16; d++)
      for (int i = 0; i < 10; i++)
        for (int j = i + 1; j < 10; j++)
          check_word(b_enc(4'(d)) ^ (10'd1 << i) ^ (10'd1 << j));
    chk(seen_c2 > 0, "R7", seen_c2, 1);
    chk(seen_amb > 0, "R8", seen_amb, 1);
  endtask

  task automatic t_busy_start;
    logic [9:0] r, ew;
    int cls, lat;
    r = b_enc(4'd9) ^ 10'b1000000001;
    b_model(r, ew, cls);
    run_word(r, 1'b1, b_enc(4'd3), lat);
    chk(lat == 47 && word_out == ew, "R10", {lat, word_out}, {47, ew});
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R10", {busy, done}, 0);
  endtask

  task automatic t_multi;
    logic [9:0] base;
    for (int a = 0; a < 10; a++)
      for (int b = a + 1; b < 10; b++)
        for (int c = b + 1; c < 10; c++)
          check_word(b_enc(4'd0) ^ (10'd1 << a) ^ (10'd1 << b) ^ (10'd1 << c));
    for (int k = 0; k < 2; k++) begin
      base = b_enc(k == 0 ? 4'd0 : 4'd9);
      for (int a = 0; a < 10; a++)
        for (int b = a + 1; b < 10; b++)
          for (int c = b + 1; c < 10; c++)
            for (int e = c + 1; e < 10; e++)
              check_word(base ^ (10'd1 << a) ^ (10'd1 << b) ^ (10'd1 << c) ^ (10'd1 << e));
    end
  endtask

  initial begin
    #(TCK * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_literal;
    t_clean;
    t_single;
    t_double;
    t_busy_start;
    t_multi;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule